// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference input with a feedback input and looks only at their rising edges. It produces a correction drive that can pull up, pull down, or float. It pulls up while the reference edge has led and the feedback edge has not yet answered. It pulls down in the opposite case. It floats when the two inputs agree. A companion lock flag is high whenever the drive floats.

Both inputs are asynchronous to the system clock and are oversampled by it. Each input passes through a synchronizer and a rising-edge detector. A three-state machine then remembers which edge came first. A decode stage turns that state into the up/down enables and a tri-state drive, which is modelled as an output-enable plus a value.

In a loop, the drive charges or discharges an external filter. The held filter value stays undisturbed while the inputs match in phase and frequency.

Top module: `pfd_top`

## Requirements
- R1: Only rising edges of `sig_in` and `cmp_in` change the detector state. Level and high time (duty cycle) have no effect on the drive.
- R2: When `sig_in` has a higher frequency than `cmp_in`, `up_en` is high for most cycles and `dn_en` never rises.
- R3: When `sig_in` has a lower frequency than `cmp_in`, `dn_en` is high for most cycles and `up_en` never rises.
- R4: At equal frequency with `sig_in` lagging `cmp_in` by N clock cycles, `dn_en` is high for exactly N cycles per period and `up_en` stays low.
- R5: At equal frequency with `cmp_in` lagging `sig_in` by N clock cycles, `up_en` is high for exactly N cycles per period and `dn_en` stays low.
- R6: When both inputs match in phase and frequency, neither enable is ever high and `lock` stays high.
- R7: The tri-state drive is encoded in two bits:
  - `drv_oe`=1 with `drv_val`=1 means pull up.
  - `drv_oe`=1 with `drv_val`=0 means pull down.
  - `drv_oe`=0 means high impedance, and `drv_val` is then 0.
  - `lock` is high exactly when `drv_oe` is low.
- R8: A leading edge is remembered: the drive it starts stays active across any number of cycles until the opposite input's rising edge arrives.
- R9: An input change applied before clock edge k appears at the outputs after clock edge k+2: two synchronizer stages, then the state register.
- R10: Rising edges of both inputs detected in the same cycle cancel. From the neutral state, no drive pulse results.
- R11: `up_en` and `dn_en` are never high together. When one is active and the opposite edge is detected, the detector is neutral after the next clock edge.
- R12: A synchronous active-high `rst` puts the detector in the neutral state with both drives off and `lock` high. It also clears the synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both inputs |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Reference (signal) input, asynchronous |
| cmp_in | input | 1 | Feedback (comparator) input, asynchronous |
| up_en | output | 1 | Pull-up driver enable |
| dn_en | output | 1 | Pull-down driver enable |
| drv_oe | output | 1 | Tri-state drive enable |
| drv_val | output | 1 | Tri-state drive value (valid when drv_oe is 1) |
| lock | output | 1 | High while neither driver is active |

## Verification
A wrong state in this block shows at the ports as a drive that starts, stops or persists in the wrong cycle. It can also show as both enables high at once. Because the outputs are decoded directly from the state register, any such error is visible at the sample taken after the third clock edge following the input change. Counting drive cycles over whole input periods turns a single wrong transition into a measurable difference from the exact lag in cycles. In particular, a lost memory of the leading edge, or a missed cancellation of simultaneous edges, changes that count.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Detector memory: which input's rising edge is waiting for its partner.
    typedef enum logic [1:0] {
        PD_NEUTRAL = 2'b00,
        PD_PUMP_UP = 2'b01,
        PD_PUMP_DN = 2'b10
    } pd_state_e;

    // Number of inputs handled by the front end (reference, feedback).
    localparam int PD_NUM_IN  = 2;
    localparam int PD_IDX_SIG = 0;
    localparam int PD_IDX_CMP = 1;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] pipe;
        logic         last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[TOP-1:0], din};
        st_d.last = st_q.pipe[TOP];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.pipe[TOP] & ~st_q.last;

    // A detected edge is a single-cycle pulse, whatever the input high time.
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R1

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_rise,
    input  logic      cmp_rise,
    output pd_state_e state
);

    typedef struct packed {
        pd_state_e st;
    } core_st_t;

    core_st_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        unique case (core_q.st)
            PD_NEUTRAL: begin
                if (sig_rise && !cmp_rise)      core_d.st = PD_PUMP_UP;
                else if (cmp_rise && !sig_rise) core_d.st = PD_PUMP_DN;
                else                            core_d.st = PD_NEUTRAL;
            end
            PD_PUMP_UP: begin
                if (cmp_rise) core_d.st = PD_NEUTRAL;
            end
            PD_PUMP_DN: begin
                if (sig_rise) core_d.st = PD_NEUTRAL;
            end
            default: core_d.st = PD_NEUTRAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) core_q.st <= PD_NEUTRAL;
        else     core_q    <= core_d;
    end

    assign state = core_q.st;

    AST_UP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == PD_PUMP_UP && cmp_rise) |=> (state == PD_NEUTRAL)); // R11
    AST_DN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == PD_PUMP_DN && sig_rise) |=> (state == PD_NEUTRAL)); // R11
    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (state == PD_NEUTRAL && sig_rise && cmp_rise) |=> (state == PD_NEUTRAL)); // R10
    AST_UP_MEMORY: assert property (@(posedge clk) disable iff (rst)
        (state == PD_PUMP_UP && !cmp_rise) |=> (state == PD_PUMP_UP)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == PD_NEUTRAL && !sig_rise && !cmp_rise) |=> (state == PD_NEUTRAL)); // R6

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pd_state_e state,
    output logic      up_en,
    output logic      dn_en,
    output logic      drv_oe,
    output logic      drv_val,
    output logic      lock
);

    typedef struct packed {
        logic up;
        logic dn;
        logic oe;
        logic val;
        logic lk;
    } drv_t;

    drv_t drv_d;

    always_comb begin
        drv_d     = '0;
        drv_d.up  = (state == PD_PUMP_UP);
        drv_d.dn  = (state == PD_PUMP_DN);
        drv_d.oe  = drv_d.up | drv_d.dn;
        drv_d.val = drv_d.up;
        drv_d.lk  = ~drv_d.oe;
    end

    assign up_en   = drv_d.up;
    assign dn_en   = drv_d.dn;
    assign drv_oe  = drv_d.oe;
    assign drv_val = drv_d.val;
    assign lock    = drv_d.lk;

    AST_DRV_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_en, dn_en})); // R11

endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic cmp_in,
    output logic up_en,
    output logic dn_en,
    output logic drv_oe,
    output logic drv_val,
    output logic lock
);

    logic [PD_NUM_IN-1:0] raw_in;
    logic [PD_NUM_IN-1:0] rise_vec;
    pd_state_e            state;

    assign raw_in[PD_IDX_SIG] = sig_in;
    assign raw_in[PD_IDX_CMP] = cmp_in;

    for (genvar g = 0; g < PD_NUM_IN; g++) begin : g_front
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .rise (rise_vec[g])
        );
    end

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .sig_rise (rise_vec[PD_IDX_SIG]),
        .cmp_rise (rise_vec[PD_IDX_CMP]),
        .state    (state)
    );

    pfd_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .up_en   (up_en),
        .dn_en   (dn_en),
        .drv_oe  (drv_oe),
        .drv_val (drv_val),
        .lock    (lock)
    );

    AST_LOCK_FLOAT: assert property (@(posedge clk) disable iff (rst)
        lock |-> (!up_en && !dn_en)); // R7

endmodule

// File: tb/sim_pfd_top.sv
module sim_pfd_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic cmp_in = 1'b0;
    logic up_en, dn_en, drv_oe, drv_val, lock;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfd_top u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .cmp_in(cmp_in),
        .up_en(up_en), .dn_en(dn_en), .drv_oe(drv_oe), .drv_val(drv_val), .lock(lock)
    );

    // Entry: {sig, cmp, exp_up, exp_dn}. The expected pair is sampled before
    // driving that step and reflects the inputs of three steps earlier (R9).
    localparam logic [3:0] VEC [0:19] = '{
        4'b0000, 4'b1000, 4'b1000, 4'b0000, 4'b0010,
        4'b0110, 4'b0010, 4'b0010, 4'b0000, 4'b0100,
        4'b0000, 4'b0000, 4'b1001, 4'b1001, 4'b0001,
        4'b1100, 4'b1100, 4'b0000, 4'b0000, 4'b0000
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_encoding(input string req);
        chk({req, " oe"}, int'(drv_oe), int'(up_en | dn_en));
        chk({req, " val"}, int'(drv_val), int'(up_en));
        chk({req, " lock"}, int'(lock), int'(!(up_en | dn_en)));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sig_in = 1'b0; cmp_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Periodic stimulus; counts drive cycles over a window after settling.
    task automatic run_wave(input int per_s, input int hi_s, input int off_s,
                            input int per_c, input int hi_c, input int off_c,
                            output int n_up, output int n_dn, output int n_lock,
                            output int n_bad);
        n_up = 0; n_dn = 0; n_lock = 0; n_bad = 0;
        for (int t = 0; t < 128; t++) begin
            @(negedge clk);
            if (t >= 64) begin
                n_up   += int'(up_en);
                n_dn   += int'(dn_en);
                n_lock += int'(lock);
                if ((up_en && dn_en) || (drv_oe != (up_en | dn_en)) ||
                    (lock != !drv_oe) || (drv_val != up_en))
                    n_bad++;
            end
            sig_in = (((t + 4*per_s - off_s) % per_s) < hi_s);
            cmp_in = (((t + 4*per_c - off_c) % per_c) < hi_c);
        end
    endtask

    initial begin
        int u, d, l, b;
        do_reset();
        @(negedge clk);
        chk("R12 reset up", int'(up_en), 0);
        chk("R12 reset dn", int'(dn_en), 0);
        chk("R12 reset lock", int'(lock), 1);
        chk("R12 reset oe", int'(drv_oe), 0);

        // Vector walk: R8 memory, R9 latency, R10 cancel, R11 release.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk($sformatf("R9/R8/R10/R11 step %0d up", i), int'(up_en), int'(VEC[i][1]));
            chk($sformatf("R9/R8/R10/R11 step %0d dn", i), int'(dn_en), int'(VEC[i][0]));
            chk_encoding($sformatf("R7 step %0d", i));
            sig_in = VEC[i][3];
            cmp_in = VEC[i][2];
        end

        // R2: signal twice as fast; up for 15 of 16 cycles.
        do_reset();
        run_wave(8, 4, 1, 16, 8, 0, u, d, l, b);
        chk("R2 up cycles", u, 60);
        chk("R2 dn cycles", d, 0);
        chk("R11 R7 encoding faster", b, 0);

        // R3: signal half as fast.
        do_reset();
        run_wave(16, 8, 0, 8, 4, 1, u, d, l, b);
        chk("R3 dn cycles", d, 60);
        chk("R3 up cycles", u, 0);

        // R4: signal lags by 3 cycles.
        do_reset();
        run_wave(16, 8, 3, 16, 8, 0, u, d, l, b);
        chk("R4 dn cycles", d, 12);
        chk("R4 up cycles", u, 0);
        chk("R7 lock cycles lag", l, 52);

        // R1: same lag, very different duty cycles.
        do_reset();
        run_wave(16, 1, 3, 16, 13, 0, u, d, l, b);
        chk("R1 dn cycles duty", d, 12);
        chk("R1 up cycles duty", u, 0);

        // R5: comparator lags by 5 cycles.
        do_reset();
        run_wave(16, 8, 0, 16, 8, 5, u, d, l, b);
        chk("R5 up cycles", u, 20);
        chk("R5 dn cycles", d, 0);

        // R6: matched phase and frequency.
        do_reset();
        run_wave(16, 8, 0, 16, 8, 0, u, d, l, b);
        chk("R6 up cycles", u, 0);
        chk("R6 dn cycles", d, 0);
        chk("R6 lock cycles", l, 64);

        // R12: reset from an active drive.
        do_reset();
        @(negedge clk); sig_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12 pre-reset up", int'(up_en), 1);
        rst = 1'b1; sig_in = 1'b0;
        @(negedge clk);
        chk("R12 reset clears up", int'(up_en), 0);
        chk("R12 reset lock high", int'(lock), 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 neutral after release", int'(drv_oe), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule